// File: doc/BRIEF.md
# Serial Flash Identification Probe

This block is a small SPI master sequencer that finds out what kind of serial flash is attached. A one-cycle `start` pulse makes it pull chip select low and send the standard read-identification command. It then clocks three dummy bytes and captures the three bytes the flash returns: manufacturer, device type and capacity code.

The block turns the capacity code into a base-2 exponent of the device size in bytes. The code numbering has a gap, so the decode is done in two ranges. Any other code is reported as unrecognised. The block also reports whether a device of that size needs 4-byte addressing.

Results are registered and stay unchanged until the next probe completes. A controller uses the `busy`/`done` handshake to know when they are fresh. The serial clock is the system clock divided down by a parameter.

Top module: `flash_id_probe`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `busy` and `done` are 0, and every result output is 0.
- R2: A `start` pulse seen while idle drives `cs_n` low and raises `busy` on the next clock edge.
- R3: SPI mode 0. `sck` is low whenever `cs_n` is high. `mosi` only changes while `sck` is low. `miso` is sampled on each rising `sck` edge. Bits are sent and received most significant bit first.
- R4: The bits on `mosi` at the 32 rising `sck` edges are command byte 0x9F followed by 24 zero bits.
- R5: `cs_n` stays low for exactly 32 rising `sck` edges and rises once per probe.
- R6: Bits 8 to 15 received on `miso` (counting from 0 at the first edge) go to `id_mfr`, bits 16 to 23 to `id_dev`, and bits 24 to 31 to `id_cap`. Bits 0 to 7 are ignored.
- R7: Capacity codes 0x17, 0x18 and 0x19 give `size_exp` equal to the code (23, 24, 25) with `id_valid` = 1.
- R8: Capacity codes 0x20, 0x21 and 0x22 give `size_exp` 26, 27 and 28 with `id_valid` = 1.
- R9: Any other capacity code, including 0x1A to 0x1F, gives `id_valid` = 0 and `size_exp` = 0.
- R10: `addr4` is 1 exactly when `id_valid` is 1 and `size_exp` is greater than 24.
- R11: `done` is high for exactly one cycle. That cycle is the one in which `cs_n` rises, 65*SCK_HALF cycles after the edge that accepted `start`. `busy` falls in the same cycle.
- R12: A `start` pulse while `busy` is high has no effect. Timing, edge count and results match an undisturbed probe.
- R13: Result outputs change only in the cycle where `done` is 1, and hold their values afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a probe (sampled while idle) |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data to flash |
| miso | input | 1 | SPI data from flash |
| cs_n | output | 1 | Active-low chip select |
| id_mfr | output | 8 | Manufacturer byte |
| id_dev | output | 8 | Device type byte |
| id_cap | output | 8 | Raw capacity code |
| size_exp | output | EXP_W | log2 of device size in bytes, 0 if unrecognised |
| id_valid | output | 1 | Capacity code recognised |
| addr4 | output | 1 | Device needs 4-byte addressing |

## Verification
`cs_n` and `busy` change one edge after `start` is accepted. Each `sck` edge falls SCK_HALF cycles after the previous one. `done` and the results arrive exactly 65*SCK_HALF edges after the accepting edge: 64 half periods of serial clock plus one half period of chip-select hold. The bench counts clock edges from the accepting edge, sampling at falling clock edges. It requires `done` to appear at exactly that count, and reads `cs_n`, `busy` and the results at that same sample.

Mode-0 framing is tracked at the serial pins by a flash model that counts rising `sck` edges. The model records `mosi` at each edge and serves the response bits from its edge count. This checks edge count, command bits and byte placement without relying on any internal signal.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;

   localparam int ID_CMD_BITS  = 8;
   localparam int ID_RESP_BYTES = 3;
   localparam int ID_RESP_BITS = 8 * ID_RESP_BYTES;
   localparam int ID_TOTAL_BITS = ID_CMD_BITS + ID_RESP_BITS;

   // capacity code ranges (the numbering skips 0x1A..0x1F)
   localparam logic [7:0] CAP_LO_FIRST = 8'h17;
   localparam logic [7:0] CAP_LO_LAST  = 8'h19;
   localparam logic [7:0] CAP_HI_FIRST = 8'h20;
   localparam logic [7:0] CAP_HI_LAST  = 8'h22;
   localparam int         CAP_HI_EXP0  = 26;
   localparam logic [7:0] CAP_HI_BIAS  = CAP_HI_FIRST - 8'(CAP_HI_EXP0);

   typedef enum logic [1:0] {
      PRB_IDLE  = 2'd0,
      PRB_SHIFT = 2'd1,
      PRB_HOLD  = 2'd2
   } probe_state_t;

   typedef struct packed {
      logic [7:0] mfr;
      logic [7:0] dev;
      logic [7:0] cap;
   } id_bytes_t;

endpackage

// File: rtl/flash_id_tick.sv
module flash_id_tick #(
   parameter int SCK_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (SCK_HALF == 1) begin : g_every_cycle
         assign tick = run;
      end else begin : g_counter
         localparam int CW = $clog2(SCK_HALF);
         localparam logic [CW-1:0] CNT_LAST = CW'(SCK_HALF - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run || cnt_q == CNT_LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick = run && (cnt_q == CNT_LAST);
      end
   endgenerate

endmodule

// File: rtl/flash_id_shifter.sv
module flash_id_shifter #(
   parameter logic [7:0] CMD        = 8'h9F,
   parameter int         TOTAL_BITS = 32,
   parameter int         RESP_BITS  = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 rise,
   input  logic                 fall,
   input  logic                 miso,
   output logic                 mosi,
   output logic                 last_bit,
   output logic [RESP_BITS-1:0] rx
);

   localparam int BCW = $clog2(TOTAL_BITS);
   localparam logic [BCW-1:0] BIT_LAST = BCW'(TOTAL_BITS - 1);

   logic [TOTAL_BITS-1:0] tx_q;
   logic [RESP_BITS-1:0]  rx_q;
   logic [BCW-1:0]        bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q  <= '0;
         bit_q <= '0;
      end else if (load) begin
         tx_q  <= {CMD, {(TOTAL_BITS-8){1'b0}}};
         bit_q <= '0;
      end else if (fall) begin
         tx_q  <= {tx_q[TOTAL_BITS-2:0], 1'b0};
         bit_q <= bit_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= '0;
      end else if (rise) begin
         rx_q <= {rx_q[RESP_BITS-2:0], miso};
      end
   end

   assign mosi     = tx_q[TOTAL_BITS-1];
   assign last_bit = (bit_q == BIT_LAST);
   assign rx       = rx_q;

endmodule

// File: rtl/flash_id_cap_decode.sv
module flash_id_cap_decode
   import flash_id_pkg::*;
#(
   parameter int EXP_W     = 6,
   parameter int ADDR4_EXP = 25
) (
   input  logic [7:0]       code,
   output logic             valid,
   output logic [EXP_W-1:0] exp_out,
   output logic             addr4
);

   logic in_lo, in_hi;

   always_comb begin
      in_lo   = (code >= CAP_LO_FIRST) && (code <= CAP_LO_LAST);
      in_hi   = (code >= CAP_HI_FIRST) && (code <= CAP_HI_LAST);
      valid   = in_lo || in_hi;
      exp_out = '0;
      if (in_lo) begin
         exp_out = EXP_W'(code);
      end else if (in_hi) begin
         exp_out = EXP_W'(code - CAP_HI_BIAS);
      end
      addr4 = valid && (exp_out >= EXP_W'(ADDR4_EXP));
   end

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
   import flash_id_pkg::*;
#(
   parameter int         SCK_HALF  = 4,
   parameter logic [7:0] ID_CMD    = 8'h9F,
   parameter int         EXP_W     = 6,
   parameter int         ADDR4_EXP = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic             sck,
   output logic             mosi,
   input  logic             miso,
   output logic             cs_n,
   output logic [7:0]       id_mfr,
   output logic [7:0]       id_dev,
   output logic [7:0]       id_cap,
   output logic [EXP_W-1:0] size_exp,
   output logic             id_valid,
   output logic             addr4
);

   generate
      if (SCK_HALF < 1) begin : g_bad_half
         $error("SCK_HALF must be at least 1");
      end
      if (EXP_W < 5) begin : g_bad_expw
         $error("EXP_W must hold exponents up to 28");
      end
      if (ADDR4_EXP >= (1 << EXP_W)) begin : g_bad_a4
         $error("ADDR4_EXP does not fit in EXP_W");
      end
   endgenerate

   probe_state_t           state_q;
   logic                   sck_q, cs_n_q, done_q;
   logic                   tick, rise, fall, load, last_bit;
   logic [ID_RESP_BITS-1:0] rx;
   id_bytes_t              rx_ids, ids_q;
   logic                   dec_valid, dec_addr4;
   logic [EXP_W-1:0]       dec_exp;
   logic [EXP_W-1:0]       exp_q;
   logic                   valid_q, addr4_q;

   assign load = (state_q == PRB_IDLE) && start;
   assign rise = (state_q == PRB_SHIFT) && tick && !sck_q;
   assign fall = (state_q == PRB_SHIFT) && tick && sck_q && !last_bit;

   flash_id_tick #(.SCK_HALF(SCK_HALF)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q != PRB_IDLE),
      .tick  (tick)
   );

   flash_id_shifter #(
      .CMD        (ID_CMD),
      .TOTAL_BITS (ID_TOTAL_BITS),
      .RESP_BITS  (ID_RESP_BITS)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .rise     (rise),
      .fall     (fall),
      .miso     (miso),
      .mosi     (mosi),
      .last_bit (last_bit),
      .rx       (rx)
   );

   assign rx_ids = id_bytes_t'(rx);

   flash_id_cap_decode #(.EXP_W(EXP_W), .ADDR4_EXP(ADDR4_EXP)) u_dec (
      .code    (rx_ids.cap),
      .valid   (dec_valid),
      .exp_out (dec_exp),
      .addr4   (dec_addr4)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PRB_IDLE;
         sck_q   <= 1'b0;
         cs_n_q  <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            PRB_IDLE: begin
               if (start) begin
                  state_q <= PRB_SHIFT;
                  cs_n_q  <= 1'b0;
                  sck_q   <= 1'b0;
               end
            end
            PRB_SHIFT: begin
               if (tick) begin
                  sck_q <= !sck_q;
                  if (sck_q && last_bit) begin
                     state_q <= PRB_HOLD;
                  end
               end
            end
            PRB_HOLD: begin
               if (tick) begin
                  state_q <= PRB_IDLE;
                  cs_n_q  <= 1'b1;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= PRB_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ids_q   <= '0;
         exp_q   <= '0;
         valid_q <= 1'b0;
         addr4_q <= 1'b0;
      end else if (state_q == PRB_HOLD && tick) begin
         ids_q   <= rx_ids;
         exp_q   <= dec_exp;
         valid_q <= dec_valid;
         addr4_q <= dec_addr4;
      end
   end

   assign busy     = (state_q != PRB_IDLE);
   assign done     = done_q;
   assign sck      = sck_q;
   assign cs_n     = cs_n_q;
   assign id_mfr   = ids_q.mfr;
   assign id_dev   = ids_q.dev;
   assign id_cap   = ids_q.cap;
   assign size_exp = exp_q;
   assign id_valid = valid_q;
   assign addr4    = addr4_q;

endmodule

// File: rtl/flash_id_probe_chk.sv
module flash_id_probe_chk #(
   parameter int EXP_W     = 6,
   parameter int ADDR4_EXP = 25
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             sck,
   input logic             mosi,
   input logic             cs_n,
   input logic [7:0]       id_mfr,
   input logic [7:0]       id_dev,
   input logic [7:0]       id_cap,
   input logic [EXP_W-1:0] size_exp,
   input logic             id_valid,
   input logic             addr4
);

   assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && !cs_n));

   assert_sck_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);

   assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));

   assert_cs_follows_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);

   assert_invalid_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !id_valid |-> (size_exp == '0));

   assert_addr4_rule_R10: assert property (@(posedge clk) disable iff (!rst_n)
      addr4 == (id_valid && (size_exp >= EXP_W'(ADDR4_EXP))));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_at_cs_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (done && !busy));

   assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && cs_n == 1'b0 && !done) |=> (busy || done));

   assert_results_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(id_mfr) && $stable(id_dev) && $stable(id_cap)
                 && $stable(size_exp) && $stable(id_valid) && $stable(addr4)));

endmodule

bind flash_id_probe flash_id_probe_chk #(.EXP_W(EXP_W), .ADDR4_EXP(ADDR4_EXP)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .sck      (sck),
   .mosi     (mosi),
   .cs_n     (cs_n),
   .id_mfr   (id_mfr),
   .id_dev   (id_dev),
   .id_cap   (id_cap),
   .size_exp (size_exp),
   .id_valid (id_valid),
   .addr4    (addr4)
);

// File: tb/flash_id_probe_tb.sv
`timescale 1ns/1ps
module flash_id_probe_tb;

   localparam int HALF  = 2;
   localparam int EXP_W = 6;
   localparam int DUR   = 65 * HALF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic busy, done, sck, mosi, cs_n, id_valid, addr4;
   logic miso;
   logic [7:0] id_mfr, id_dev, id_cap;
   logic [EXP_W-1:0] size_exp;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   flash_id_probe #(.SCK_HALF(HALF), .EXP_W(EXP_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n),
      .id_mfr(id_mfr), .id_dev(id_dev), .id_cap(id_cap),
      .size_exp(size_exp), .id_valid(id_valid), .addr4(addr4)
   );

   // flash model: mode 0, serves the next bit after each rising edge
   logic [31:0] resp_word = 32'h0;
   logic [31:0] mosi_seen = 32'h0;
   int rise_cnt = 0;
   int cs_rises = 0;
   int done_cnt = 0;

   always @(posedge sck) if (!cs_n) begin
      mosi_seen <= {mosi_seen[30:0], mosi};
      rise_cnt  <= rise_cnt + 1;
   end
   always @(posedge cs_n) cs_rises <= cs_rises + 1;
   always @(posedge clk) if (rst_n && done) done_cnt <= done_cnt + 1;

   assign miso = (!cs_n && rise_cnt < 32) ? resp_word[31 - rise_cnt] : 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // runs one probe; extra_at >= 0 pulses start again that many samples in
   task automatic run_probe(input logic [7:0] mfr, input logic [7:0] dev,
                            input logic [7:0] cap, input int exp_e,
                            input bit exp_v, input bit exp_a4, input int extra_at);
      int n;
      @(negedge clk);
      resp_word = {8'hA5, mfr, dev, cap};   // first byte must be ignored (R6)
      rise_cnt  = 0;
      cs_rises  = 0;
      done_cnt  = 0;
      start     = 1'b1;
      n = -1;
      for (int i = 0; i < 4 * DUR; i++) begin
         @(negedge clk);
         start = 1'b0;
         if (i == 0) begin
            check(!cs_n && busy, "R2", {cs_n, busy}, 2'b01);
         end
         if (i == extra_at) start = 1'b1;
         if (i == extra_at + 1) start = 1'b0;
         if (done) begin n = i; break; end
      end
      start = 1'b0;
      check(n == DUR, "R11 done timing", n, DUR);
      check(cs_n && !busy, "R11 cs/busy at done", {cs_n, busy}, 2'b10);
      check(rise_cnt == 32, "R5 sck rising edges", rise_cnt, 32);
      check(cs_rises == 1, "R5 cs rises", cs_rises, 1);
      check(mosi_seen == 32'h9F00_0000, "R4 mosi bits", mosi_seen, 32'h9F00_0000);
      check({id_mfr, id_dev, id_cap} == {mfr, dev, cap}, "R6 id bytes",
            {id_mfr, id_dev, id_cap}, {mfr, dev, cap});
      check(size_exp == EXP_W'(exp_e) && id_valid == exp_v,
            (exp_e == 0) ? "R9 decode" : (exp_e <= 25 ? "R7 decode" : "R8 decode"),
            {size_exp, id_valid}, {EXP_W'(exp_e), exp_v});
      check(addr4 == exp_a4, "R10 addr4", addr4, exp_a4);
      @(negedge clk);
      check(!done && done_cnt == 1, "R11 done single", done_cnt, 1);
      if (extra_at >= 0) check(!busy && cs_n, "R12 no restart", {busy, cs_n}, 2'b01);
   endtask

   task automatic test_reset();
      check(cs_n === 1'b1 && sck === 1'b0 && busy === 1'b0 && done === 1'b0,
            "R1 ctrl", {cs_n, sck, busy, done}, 4'b1000);
      check({id_mfr, id_dev, id_cap, size_exp, id_valid, addr4} === '0, "R1 results",
            {id_mfr, id_dev, id_cap}, 0);
   endtask

   task automatic test_hold();
      logic [31:0] snap;
      snap = {id_mfr, id_dev, id_cap, 2'b00, id_valid, addr4};
      repeat (25) @(negedge clk);
      check({id_mfr, id_dev, id_cap, 2'b00, id_valid, addr4} == snap && sck == 1'b0,
            "R13 hold", {id_mfr, id_dev, id_cap, 2'b00, id_valid, addr4}, snap);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      test_reset();
      run_probe(8'h20, 8'hBA, 8'h18, 24, 1'b1, 1'b0, -1);  // R7 16 MiB
      run_probe(8'hEF, 8'h40, 8'h17, 23, 1'b1, 1'b0, -1);  // R7
      run_probe(8'h01, 8'h20, 8'h19, 25, 1'b1, 1'b1, -1);  // R7 R10
      run_probe(8'hC2, 8'h20, 8'h20, 26, 1'b1, 1'b1, -1);  // R8
      run_probe(8'h20, 8'hBA, 8'h21, 27, 1'b1, 1'b1, -1);  // R8
      run_probe(8'h55, 8'hAA, 8'h22, 28, 1'b1, 1'b1, -1);  // R8
      test_hold();
      run_probe(8'h01, 8'h02, 8'h1A, 0, 1'b0, 1'b0, -1);   // R9 gap start
      run_probe(8'h80, 8'h01, 8'h1F, 0, 1'b0, 1'b0, -1);   // R9 gap end
      run_probe(8'hFF, 8'hFF, 8'h16, 0, 1'b0, 1'b0, -1);   // R9 below
      run_probe(8'h00, 8'h00, 8'h23, 0, 1'b0, 1'b0, -1);   // R9 above
      run_probe(8'h9D, 8'h60, 8'h21, 27, 1'b1, 1'b1, 40);  // R12 start while busy
      run_probe(8'h9D, 8'h60, 8'h18, 24, 1'b1, 1'b0, DUR - 3); // R12 near end
      test_hold();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule